// File: doc/BRIEF.md
# Registered Command/Address Buffer with Gated Parity Check

This block sits between a memory controller and a module's DRAM devices. It registers the address/command bus, the chip selects, the clock enables and the termination controls on the rising clock edge. It then drives every registered bit to two matching output copies, an A side and a B side, so that one input bus can feed two banks of loads. A static strap sets the chip-select fan-out. In pair mode, two select inputs are each copied to two outputs. In quad mode, four select inputs each reach their own output.

The block also protects the address/command bus with one parity bit. The controller delivers this bit one clock after the word it covers. The block compares it with the XOR of that word's address/command bits. The check is made only when the word was issued with at least one chip select active. The selects, clock enables and termination controls take no part in the parity. A mismatch pulls an active-low error flag low for a fixed number of cycles, which is two by default. A further mismatch during that time restarts the count.

All pins are plain signals. There is no valid/ready handshake at the boundary: the bus is sampled on every edge and the block never stalls the sender, so there is no back-pressure.

Top module: `cmdbuf_reg`

## Requirements
- R1: The address/command, clock-enable and termination outputs show the values sampled at the previous rising edge, so the latency is one cycle.
- R2: The A-side and B-side copies of every address/command, clock-enable and termination bit are always equal.
- R3: If a word was captured with a chip select active, and `par_in` at the next edge differs from the XOR of that word's `ac_in` bits, a parity error is detected at that next edge.
- R4: Clock-enable and termination inputs do not affect the parity result. A word with matching parity raises no error whatever their values.
- R5: A word captured with no active chip select in the mode in use is never checked. A wrong parity bit for that word leaves `err_n` high.
- R6: After an error is detected at an edge, `err_n` is low during the following two cycles and then returns high. A new error during the hold restarts the two-cycle window.
- R7: When `cs_pair_mode`=1, only `cs_n_in[1:0]` are used. `cs_n_q[1:0]` (A side) and `cs_n_q[3:2]` (B side) both carry the registered `cs_n_in[1:0]`. `cs_n_in[3:2]` do not reach any output and do not enable the parity check.
- R8: When `cs_pair_mode`=0, `cs_n_q[i]` carries the registered `cs_n_in[i]` for i=0..3. Any one of the four being low enables the check. All chip selects are active low.
- R9: A synchronous active-high `rst` sets all data outputs to 0, sets `cs_n_q` to all ones and sets `err_n` high. It also cancels a pending error hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_pair_mode | input | 1 | Strap: 1 = two selects duplicated, 0 = four selects one-to-one |
| cs_n_in | input | 4 | Chip selects, active low |
| ac_in | input | AC_W (22) | Address/command bus |
| cke_in | input | CTL_W (2) | Clock enables |
| odt_in | input | CTL_W (2) | Termination controls |
| par_in | input | 1 | Parity for the word sampled one edge earlier |
| ac_a_q | output | AC_W | Address/command, A copy |
| ac_b_q | output | AC_W | Address/command, B copy |
| cke_a_q | output | CTL_W | Clock enables, A copy |
| cke_b_q | output | CTL_W | Clock enables, B copy |
| odt_a_q | output | CTL_W | Termination, A copy |
| odt_b_q | output | CTL_W | Termination, B copy |
| cs_n_q | output | 4 | Registered chip selects (A side [1:0], B side [3:2] in pair mode) |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The bench builds the block with its default parameters: a 22-bit address/command bus, two clock-enable and two termination bits, and an error hold of two cycles. At these values a single vector table can cover both strap settings, patterns with odd and even bit counts, all-ones and all-zeros words, and the ignored upper selects in pair mode. The two-cycle hold keeps the release and restart of the error flag short enough to check edge by edge in directed tests.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  localparam int unsigned CS_N = 4;
  localparam int unsigned CS_PAIR = 2;

  typedef enum logic {
    CS_QUAD = 1'b0,
    CS_PAIR_DUP = 1'b1
  } cs_mode_e;
endpackage

// File: rtl/cmdbuf_fanout.sv
module cmdbuf_fanout #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  localparam int unsigned COPIES = 2;

  logic [COPIES-1:0][W-1:0] q;

  generate
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
      always_ff @(posedge clk) begin
        if (rst) q[c] <= '0;
        else     q[c] <= d;
      end
    end
  endgenerate

  assign q_a = q[0];
  assign q_b = q[1];

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_copies_equal_R2: assert property (@(posedge clk) disable iff (rst)
    q_a == q_b);
  assert_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    live |-> (q_a == $past(d)));
endmodule

// File: rtl/cmdbuf_cs_map.sv
module cmdbuf_cs_map
  import cmdbuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pair_mode,
  input  logic [CS_N-1:0] cs_n_in,
  output logic [CS_N-1:0] cs_n_q,
  output logic            any_active
);
  logic [CS_N-1:0] mapped;
  logic [CS_N-1:0] used_mask;
  cs_mode_e        mode;

  assign mode = pair_mode ? CS_PAIR_DUP : CS_QUAD;

  always_comb begin
    mapped    = cs_n_in;
    used_mask = '1;
    if (mode == CS_PAIR_DUP) begin
      used_mask = '0;
      for (int i = 0; i < CS_N; i++) begin
        mapped[i] = cs_n_in[i % CS_PAIR];
        if (i < CS_PAIR) used_mask[i] = 1'b1;
      end
    end
  end

  assign any_active = |(~cs_n_in & used_mask);

  always_ff @(posedge clk) begin
    if (rst) cs_n_q <= '1;
    else     cs_n_q <= mapped;
  end

  logic live;
  logic mode_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      live   <= 1'b1;
      mode_q <= pair_mode;
    end
  end

  assert_pair_dup_R7: assert property (@(posedge clk) disable iff (rst)
    (live && mode_q) |-> (cs_n_q[1:0] == cs_n_q[3:2] && cs_n_q[1:0] == $past(cs_n_in[1:0])));
  assert_quad_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (live && !mode_q) |-> (cs_n_q == $past(cs_n_in)));
endmodule

// File: rtl/cmdbuf_parity_chk.sv
module cmdbuf_parity_chk #(
  parameter int unsigned AC_W = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AC_W-1:0] ac_in,
  input  logic            any_active,
  input  logic            par_in,
  output logic            err_pulse
);
  logic calc_q;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      calc_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      calc_q <= ^ac_in;
      gate_q <= any_active;
    end
  end

  assign err_pulse = gate_q && (calc_q != par_in);

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_gated_off_R5: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(any_active)) |-> !err_pulse);
  assert_mismatch_seen_R3: assert property (@(posedge clk) disable iff (rst)
    (live && $past(any_active) && (par_in != $past(^ac_in))) |-> err_pulse);
endmodule

// File: rtl/cmdbuf_err_stretch.sv
module cmdbuf_err_stretch #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic err_pulse,
  output logic err_n
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (err_pulse)    cnt <= HOLD_V;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign err_n = (cnt == '0);

  assert_err_drop_R6: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_n);
  assert_err_release_R6: assert property (@(posedge clk) disable iff (rst)
    (err_n && !err_pulse) |=> err_n);
endmodule

// File: rtl/cmdbuf_reg.sv
module cmdbuf_reg
  import cmdbuf_pkg::*;
#(
  parameter int unsigned AC_W  = 22,
  parameter int unsigned CTL_W = 2,
  parameter int unsigned HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_pair_mode,
  input  logic [CS_N-1:0]  cs_n_in,
  input  logic [AC_W-1:0]  ac_in,
  input  logic [CTL_W-1:0] cke_in,
  input  logic [CTL_W-1:0] odt_in,
  input  logic             par_in,
  output logic [AC_W-1:0]  ac_a_q,
  output logic [AC_W-1:0]  ac_b_q,
  output logic [CTL_W-1:0] cke_a_q,
  output logic [CTL_W-1:0] cke_b_q,
  output logic [CTL_W-1:0] odt_a_q,
  output logic [CTL_W-1:0] odt_b_q,
  output logic [CS_N-1:0]  cs_n_q,
  output logic             err_n
);
  logic any_active;
  logic err_pulse;

  cmdbuf_fanout #(.W(AC_W)) u_ac (
    .clk(clk), .rst(rst), .d(ac_in), .q_a(ac_a_q), .q_b(ac_b_q)
  );
  cmdbuf_fanout #(.W(CTL_W)) u_cke (
    .clk(clk), .rst(rst), .d(cke_in), .q_a(cke_a_q), .q_b(cke_b_q)
  );
  cmdbuf_fanout #(.W(CTL_W)) u_odt (
    .clk(clk), .rst(rst), .d(odt_in), .q_a(odt_a_q), .q_b(odt_b_q)
  );

  cmdbuf_cs_map u_cs (
    .clk(clk), .rst(rst), .pair_mode(cs_pair_mode), .cs_n_in(cs_n_in),
    .cs_n_q(cs_n_q), .any_active(any_active)
  );

  cmdbuf_parity_chk #(.AC_W(AC_W)) u_par (
    .clk(clk), .rst(rst), .ac_in(ac_in), .any_active(any_active),
    .par_in(par_in), .err_pulse(err_pulse)
  );

  cmdbuf_err_stretch #(.HOLD(HOLD)) u_err (
    .clk(clk), .rst(rst), .err_pulse(err_pulse), .err_n(err_n)
  );

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_reset_state_R9: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (cs_n_q == '1 && err_n && ac_a_q == '0));
  assert_ctrl_excluded_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(any_active) && par_in == $past(^ac_in)) |-> !err_pulse);
endmodule

// File: tb/cmdbuf_reg_tb.sv
`timescale 1ns/1ps
module cmdbuf_reg_tb;
  localparam int AC_W = 22;
  localparam int CTL_W = 2;
  localparam int NV = 10;

  typedef struct packed {
    logic        dual;
    logic [3:0]  cs;
    logic [21:0] ac;
    logic [1:0]  cke;
    logic [1:0]  odt;
    logic        flip;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'b1110, 22'h0001A5, 2'b11, 2'b01, 1'b1},
    '{1'b1, 4'b1101, 22'h3FFFFF, 2'b00, 2'b10, 1'b0},
    '{1'b1, 4'b0011, 22'h012345, 2'b10, 2'b11, 1'b1},
    '{1'b1, 4'b1111, 22'h2AAAAA, 2'b01, 2'b00, 1'b1},
    '{1'b0, 4'b0111, 22'h155555, 2'b11, 2'b11, 1'b1},
    '{1'b0, 4'b1011, 22'h0F0F0F, 2'b00, 2'b01, 1'b0},
    '{1'b0, 4'b1111, 22'h00FF00, 2'b11, 2'b11, 1'b1},
    '{1'b0, 4'b0000, 22'h3C3C3C, 2'b10, 2'b10, 1'b1},
    '{1'b1, 4'b1100, 22'h000000, 2'b01, 2'b10, 1'b1},
    '{1'b1, 4'b1110, 22'h000001, 2'b11, 2'b00, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_pair_mode = 1'b1;
  logic [3:0] cs_n_in = 4'hF;
  logic [AC_W-1:0] ac_in = '0;
  logic [CTL_W-1:0] cke_in = '0;
  logic [CTL_W-1:0] odt_in = '0;
  logic par_in = 1'b0;
  logic [AC_W-1:0] ac_a_q, ac_b_q;
  logic [CTL_W-1:0] cke_a_q, cke_b_q, odt_a_q, odt_b_q;
  logic [3:0] cs_n_q;
  logic err_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmdbuf_reg u_dut (
    .clk(clk), .rst(rst), .cs_pair_mode(cs_pair_mode), .cs_n_in(cs_n_in),
    .ac_in(ac_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
    .ac_a_q(ac_a_q), .ac_b_q(ac_b_q), .cke_a_q(cke_a_q), .cke_b_q(cke_b_q),
    .odt_a_q(odt_a_q), .odt_b_q(odt_b_q), .cs_n_q(cs_n_q), .err_n(err_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic active(input logic dual, input logic [3:0] cs);
    return dual ? !(&cs[1:0]) : !(&cs);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state with busy inputs
    cs_n_in = 4'h0; ac_in = '1; cke_in = '1; odt_in = '1;
    repeat (3) @(negedge clk);
    chk("R9 ac", {ac_a_q, ac_b_q}, '0);
    chk("R9 ctl", {cke_a_q, cke_b_q, odt_a_q, odt_b_q}, '0);
    chk("R9 cs", cs_n_q, 4'hF);
    chk("R9 err", err_n, 1'b1);
    rst = 1'b0;
    cs_n_in = 4'hF; ac_in = '0; cke_in = '0; odt_in = '0;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      cs_pair_mode = VEC[v].dual;
      cs_n_in = VEC[v].cs;
      ac_in = VEC[v].ac;
      cke_in = VEC[v].cke;
      odt_in = VEC[v].odt;
      @(negedge clk);
      // R1 R2 latency and copies
      chk("R1 ac_a", ac_a_q, VEC[v].ac);
      chk("R2 ac_b", ac_b_q, VEC[v].ac);
      chk("R2 ctl", {cke_a_q, cke_b_q, odt_a_q, odt_b_q},
          {VEC[v].cke, VEC[v].cke, VEC[v].odt, VEC[v].odt});
      // R7 R8 chip-select mapping
      chk(VEC[v].dual ? "R7 cs map" : "R8 cs map", cs_n_q,
          VEC[v].dual ? {VEC[v].cs[1:0], VEC[v].cs[1:0]} : VEC[v].cs);
      cs_n_in = 4'hF;
      par_in = (^VEC[v].ac) ^ VEC[v].flip;
      @(negedge clk);
      // R3 R4 R5 gated parity
      chk("R3 R4 R5 err", err_n, !(VEC[v].flip && active(VEC[v].dual, VEC[v].cs)));
      @(negedge clk);
      @(negedge clk);
    end

    // R6: single error holds two cycles then releases
    cs_pair_mode = 1'b0; cs_n_in = 4'b1110; ac_in = 22'h000003;
    @(negedge clk);
    cs_n_in = 4'hF; par_in = 1'b1;
    @(negedge clk);
    chk("R6 low1", err_n, 1'b0);
    par_in = 1'b0;
    @(negedge clk);
    chk("R6 low2", err_n, 1'b0);
    @(negedge clk);
    chk("R6 release", err_n, 1'b1);

    // R6: back-to-back errors restart the hold
    cs_n_in = 4'b1101; ac_in = 22'h000001;
    @(negedge clk);
    ac_in = 22'h000007; par_in = 1'b0;
    @(negedge clk);
    chk("R6 first", err_n, 1'b0);
    cs_n_in = 4'hF; par_in = 1'b0;
    @(negedge clk);
    chk("R6 second", err_n, 1'b0);
    par_in = 1'b0;
    @(negedge clk);
    chk("R6 extended", err_n, 1'b0);
    @(negedge clk);
    chk("R6 end", err_n, 1'b1);

    // R9: reset cancels a pending hold
    cs_n_in = 4'b1011; ac_in = 22'h000001;
    @(negedge clk);
    cs_n_in = 4'hF; par_in = 1'b0;
    @(negedge clk);
    chk("R9 pre", err_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 cancel", err_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after", err_n, 1'b1);

    finish_run();
  end
endmodule